// File: doc/BRIEF.md
# One-Time-Programmable Byte Array Controller

This block sits behind a 32-bit register bus and gives software byte-wide access to a one-time-programmable store. Software first takes an access semaphore in a small configuration window and clears the array's power-down bit. For each byte it loads a split byte address and selects either a read or a byte program in a command register. It then writes a start strobe and polls a busy flag. When busy drops, a pass/fail flag and, for a read, a read-data register hold the result.

The store behaves like a bank of fuses. It starts with every bit at zero. A program can only move bits from 0 to 1, and each operation takes several cycles. A program that would need a stored 1 to go back to 0 is refused and leaves the byte as it was. A start that is not allowed takes no cycles and only sets the fail flag. This applies when the array is powered down, when the semaphore is not held, when the command is not valid, or when the address is outside the array. The address space is 13 bits wide (8192 bytes). The `DEPTH` parameter sets how much of that space holds storage.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset the power-down register (0x1000) reads 1. The semaphore, status, pass/fail, read-data and command registers read 0, and every array byte holds 0x00.
- R2: At config offset 0x0A0, a write copies data bit 5 into the semaphore, which reads back as 0x20 when held and 0 when free. All other data bits are ignored.
- R3: The byte address is {high[4:0], low[7:0]}, with the low byte at 0x1008 and the high bits at 0x1004. Readback is masked to 8 and 5 bits, and distinct addresses select distinct bytes up to DEPTH-1.
- R4: A read starts when the command register (0x1020) holds 1 and a write to 0x1028 has bit 0 set. Status (0x1030) bit 0 then reads 1 for exactly RD_LAT cycles (default 4). Afterwards read-data (0x1018) holds the byte and pass/fail (0x102C) reads 0.
- R5: A program starts on the same go write when the command holds 2 and program mode (0x1014) bit 0 is set. Status reads busy for PG_LAT cycles (default 16), after which the byte holds its old value OR program data (0x1010) and pass/fail reads 0.
- R6: If the program data has a 0 where the stored byte has a 1, the program completes with pass/fail at 1 and the byte unchanged.
- R7: A go is refused in any of these cases: power-down is set, the semaphore is free, the command is not 1 or 2, a program is requested with mode bit 0 clear, or the address is at least DEPTH. A refused go sets pass/fail to 1 on the next cycle, never raises busy, and changes neither the array nor read-data.
- R8: The command register reads 0 after an operation completes and after a go is refused.
- R9: A go written while busy is ignored. It neither extends the busy time nor changes the operation or its result.
- R10: Writing 1 to power-down bit 0 reads back 1 and makes later go writes fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 13 | Byte address; bit 12 selects the array window, otherwise the config window |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
Software can only see a wrong busy count through the status bit. That shows up within one operation, as a busy window one or more cycles longer or shorter than RD_LAT or PG_LAT. A byte stored wrongly, for example one with a bit cleared or a refused program that was still committed, stays hidden until that address is read back. The bench therefore reads back every programmed byte and every byte after a refused attempt. A wrong gating decision shows on the cycle after the go as a pass/fail or status value that differs, and a stuck command register shows on the next command readback.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;
  localparam int BUS_AW  = 13;
  localparam int BUS_DW  = 32;
  localparam int OFS_W   = BUS_AW - 1;
  localparam int HI_W    = 5;
  localparam int LO_W    = 8;
  localparam int BYTE_AW = HI_W + LO_W;
  localparam int LOCK_BIT = 5;

  // offsets inside each window; bit 12 of the bus address selects the window
  localparam logic [OFS_W-1:0] OFS_PWRDN   = 12'h000;
  localparam logic [OFS_W-1:0] OFS_ADDR_HI = 12'h004;
  localparam logic [OFS_W-1:0] OFS_ADDR_LO = 12'h008;
  localparam logic [OFS_W-1:0] OFS_PDATA   = 12'h010;
  localparam logic [OFS_W-1:0] OFS_PMODE   = 12'h014;
  localparam logic [OFS_W-1:0] OFS_RDATA   = 12'h018;
  localparam logic [OFS_W-1:0] OFS_FUNC    = 12'h020;
  localparam logic [OFS_W-1:0] OFS_GO      = 12'h028;
  localparam logic [OFS_W-1:0] OFS_PASSF   = 12'h02C;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 12'h030;
  localparam logic [OFS_W-1:0] OFS_LOCK    = 12'h0A0;

  localparam logic [1:0] CMD_READ = 2'b01;
  localparam logic [1:0] CMD_PROG = 2'b10;
endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BUS_DW-1:0]   bus_wdata,
  output logic [BUS_DW-1:0]   bus_rdata,
  input  logic                busy,
  input  logic                fail,
  input  logic [7:0]          rd_byte,
  input  logic                func_clr,
  output logic                pwrdn,
  output logic                lock,
  output logic [BYTE_AW-1:0]  byte_addr,
  output logic [7:0]          pgm_data,
  output logic                pgm_mode,
  output logic [1:0]          func,
  output logic                go_pulse
);
  logic              in_arr;
  logic [OFS_W-1:0]  ofs;
  logic [HI_W-1:0]   ahi, ahi_d;
  logic [LO_W-1:0]   alo, alo_d;
  logic [7:0]        pdata_d;
  logic              pwrdn_d, lock_d, pmode_d;
  logic [1:0]        func_d;
  logic              unused_wdata_hi;

  assign in_arr          = bus_addr[BUS_AW-1];
  assign ofs             = bus_addr[OFS_W-1:0];
  assign byte_addr       = {ahi, alo};
  assign go_pulse        = bus_we && in_arr && (ofs == OFS_GO) && bus_wdata[0];
  assign unused_wdata_hi = ^bus_wdata[BUS_DW-1:8];

  // next-state
  always_comb begin
    pwrdn_d = pwrdn;
    lock_d  = lock;
    ahi_d   = ahi;
    alo_d   = alo;
    pdata_d = pgm_data;
    pmode_d = pgm_mode;
    func_d  = func;
    if (bus_we) begin
      if (!in_arr) begin
        if (ofs == OFS_LOCK) lock_d = bus_wdata[LOCK_BIT];
      end else begin
        case (ofs)
          OFS_PWRDN:   pwrdn_d = bus_wdata[0];
          OFS_ADDR_HI: ahi_d   = bus_wdata[HI_W-1:0];
          OFS_ADDR_LO: alo_d   = bus_wdata[LO_W-1:0];
          OFS_PDATA:   pdata_d = bus_wdata[7:0];
          OFS_PMODE:   pmode_d = bus_wdata[0];
          OFS_FUNC:    func_d  = bus_wdata[1:0];
          default: ;
        endcase
      end
    end
    // completion or refusal clears the command, ahead of any bus write
    if (func_clr) func_d = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrdn    <= 1'b1;
      lock     <= 1'b0;
      ahi      <= '0;
      alo      <= '0;
      pgm_data <= '0;
      pgm_mode <= 1'b0;
      func     <= 2'b00;
    end else begin
      pwrdn    <= pwrdn_d;
      lock     <= lock_d;
      ahi      <= ahi_d;
      alo      <= alo_d;
      pgm_data <= pdata_d;
      pgm_mode <= pmode_d;
      func     <= func_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (!in_arr) begin
      if (ofs == OFS_LOCK) bus_rdata[LOCK_BIT] = lock;
    end else begin
      case (ofs)
        OFS_PWRDN:   bus_rdata[0]        = pwrdn;
        OFS_ADDR_HI: bus_rdata[HI_W-1:0] = ahi;
        OFS_ADDR_LO: bus_rdata[LO_W-1:0] = alo;
        OFS_PDATA:   bus_rdata[7:0]      = pgm_data;
        OFS_PMODE:   bus_rdata[0]        = pgm_mode;
        OFS_RDATA:   bus_rdata[7:0]      = rd_byte;
        OFS_FUNC:    bus_rdata[1:0]      = func;
        OFS_PASSF:   bus_rdata[0]        = fail;
        OFS_STATUS:  bus_rdata[0]        = busy;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_ctrl_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int RD_LAT = 4,
  parameter int PG_LAT = 16,
  localparam int MEM_AW = $clog2(DEPTH),
  localparam int MAXL   = (RD_LAT > PG_LAT) ? RD_LAT : PG_LAT,
  localparam int CW     = (MAXL > 2) ? $clog2(MAXL) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_pulse,
  input  logic               pwrdn,
  input  logic               lock,
  input  logic [1:0]         func,
  input  logic               pgm_mode,
  input  logic [BYTE_AW-1:0] byte_addr,
  input  logic [7:0]         pgm_data,
  input  logic [7:0]         mem_rdata,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic               mem_we,
  output logic [7:0]         mem_wdata,
  output logic               busy,
  output logic               fail,
  output logic [7:0]         rd_byte,
  output logic               func_clr,
  output logic               start,
  output logic               op_prog
);
  localparam logic [BYTE_AW:0] DEPTH_V = (BYTE_AW+1)'(DEPTH);
  localparam logic [CW-1:0]    RD_LOAD = CW'(RD_LAT - 1);
  localparam logic [CW-1:0]    PG_LOAD = CW'(PG_LAT - 1);

  logic [CW-1:0]     cnt, cnt_d;
  logic              busy_d, fail_d, prog_d;
  logic [7:0]        rd_d, odata, odata_d;
  logic [MEM_AW-1:0] oaddr, oaddr_d;
  logic              req_rd, req_pg, addr_ok, cfg_ok, go_eff, reject, done, conflict;

  assign req_rd   = (func == CMD_READ);
  assign req_pg   = (func == CMD_PROG);
  assign addr_ok  = ({1'b0, byte_addr} < DEPTH_V);
  assign cfg_ok   = !pwrdn && lock && addr_ok && (req_rd || (req_pg && pgm_mode));
  assign go_eff   = go_pulse && !busy;
  assign start    = go_eff && cfg_ok;
  assign reject   = go_eff && !cfg_ok;
  assign done     = busy && (cnt == '0);
  assign conflict = |(mem_rdata & ~odata);
  assign func_clr = reject || done;
  assign mem_addr = oaddr;
  assign mem_wdata = mem_rdata | odata;

  always_comb begin
    busy_d  = busy;
    cnt_d   = cnt;
    fail_d  = fail;
    rd_d    = rd_byte;
    prog_d  = op_prog;
    oaddr_d = oaddr;
    odata_d = odata;
    mem_we  = 1'b0;
    if (start) begin
      busy_d  = 1'b1;
      cnt_d   = req_pg ? PG_LOAD : RD_LOAD;
      fail_d  = 1'b0;
      prog_d  = req_pg;
      oaddr_d = byte_addr[MEM_AW-1:0];
      odata_d = pgm_data;
    end else if (reject) begin
      fail_d = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
      if (op_prog) begin
        fail_d = conflict;
        mem_we = !conflict;
      end else begin
        rd_d   = mem_rdata;
        fail_d = 1'b0;
      end
    end else if (busy) begin
      cnt_d = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      fail    <= 1'b0;
      rd_byte <= '0;
      op_prog <= 1'b0;
      oaddr   <= '0;
      odata   <= '0;
    end else begin
      busy    <= busy_d;
      cnt     <= cnt_d;
      fail    <= fail_d;
      rd_byte <= rd_d;
      op_prog <= prog_d;
      oaddr   <= oaddr_d;
      odata   <= odata_d;
    end
  end
endmodule

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int DEPTH = 2048,
  localparam int MEM_AW = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] addr,
  input  logic              we,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_ctrl_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int RD_LAT = 4,
  parameter int PG_LAT = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata
);
  localparam int MEM_AW = $clog2(DEPTH);

  logic [1:0]         rst_sync;
  logic               rst_sync_n;
  logic               busy, fail, func_clr, pwrdn, lock, pgm_mode, go_pulse, start, op_prog;
  logic [7:0]         rd_byte, pgm_data, mem_rdata, mem_wdata;
  logic [1:0]         func;
  logic [BYTE_AW-1:0] byte_addr;
  logic [MEM_AW-1:0]  mem_addr;
  logic               mem_we;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  fuse_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .fail(fail), .rd_byte(rd_byte), .func_clr(func_clr),
    .pwrdn(pwrdn), .lock(lock), .byte_addr(byte_addr), .pgm_data(pgm_data),
    .pgm_mode(pgm_mode), .func(func), .go_pulse(go_pulse)
  );

  fuse_seq #(.DEPTH(DEPTH), .RD_LAT(RD_LAT), .PG_LAT(PG_LAT)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .go_pulse(go_pulse), .pwrdn(pwrdn), .lock(lock), .func(func), .pgm_mode(pgm_mode),
    .byte_addr(byte_addr), .pgm_data(pgm_data), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .busy(busy), .fail(fail), .rd_byte(rd_byte), .func_clr(func_clr),
    .start(start), .op_prog(op_prog)
  );

  fuse_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .rst_n(rst_sync_n),
    .addr(mem_addr), .we(mem_we), .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk #(
  parameter int RD_LAT = 4,
  parameter int PG_LAT = 16
)(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       start,
  input logic       pwrdn,
  input logic       lock,
  input logic       op_prog,
  input logic       mem_we,
  input logic [7:0] mem_wdata,
  input logic [7:0] mem_rdata,
  input logic [1:0] func
);
  logic [31:0] bcnt;

  // busy cycles since the accepted go
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bcnt <= '0;
    else if (start) bcnt <= '0;
    else if (busy)  bcnt <= bcnt + 32'd1;
  end

  a_r7_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!pwrdn && lock));

  a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r6_bits_only_set: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata & mem_rdata) == mem_rdata));

  a_r8_func_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (func == 2'b00));

  a_r9_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == (op_prog ? PG_LAT : RD_LAT)));
endmodule

bind fuse_ctrl fuse_ctrl_chk #(.RD_LAT(RD_LAT), .PG_LAT(PG_LAT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy), .start(start), .pwrdn(pwrdn),
  .lock(lock), .op_prog(op_prog), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata), .func(func)
);

// File: tb/fuse_ctrl_bench.sv
module fuse_ctrl_bench;
  localparam int DEPTH = 2048;
  localparam logic [12:0] A_LOCK = 13'h00A0, A_PWRDN = 13'h1000, A_AHI = 13'h1004,
    A_ALO = 13'h1008, A_PDATA = 13'h1010, A_PMODE = 13'h1014, A_RDATA = 13'h1018,
    A_FUNC = 13'h1020, A_GO = 13'h1028, A_PF = 13'h102C, A_STAT = 13'h1030;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [12:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata, bus_rdata;

  fuse_ctrl u_fuse_ctrl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                         .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, finished = 0;

  // behavioural reference state
  bit m_pwrdn, m_lock, m_mode, m_busy, m_fail, m_prog;
  logic [4:0] m_ahi;
  logic [7:0] m_alo, m_pdata, m_rd, m_odata;
  logic [1:0] m_func;
  int m_cnt, m_oaddr;
  logic [7:0] m_mem [DEPTH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [12:0] a);
    case (a)
      A_LOCK:  return {26'b0, m_lock, 5'b0};
      A_PWRDN: return {31'b0, m_pwrdn};
      A_AHI:   return {27'b0, m_ahi};
      A_ALO:   return {24'b0, m_alo};
      A_PDATA: return {24'b0, m_pdata};
      A_PMODE: return {31'b0, m_mode};
      A_RDATA: return {24'b0, m_rd};
      A_FUNC:  return {30'b0, m_func};
      A_PF:    return {31'b0, m_fail};
      A_STAT:  return {31'b0, m_busy};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [12:0] a);
    case (a)
      A_LOCK:  return "R2 cycle compare";
      A_AHI, A_ALO: return "R3 cycle compare";
      A_RDATA: return "R4 cycle compare";
      A_FUNC:  return "R8 cycle compare";
      A_PF:    return "R7 cycle compare";
      A_STAT:  return "R9 cycle compare";
      A_PWRDN: return "R10 cycle compare";
      default: return "R1 cycle compare";
    endcase
  endfunction

  task automatic model_reset();
    m_pwrdn = 1; m_lock = 0; m_mode = 0; m_busy = 0; m_fail = 0; m_prog = 0;
    m_ahi = 0; m_alo = 0; m_pdata = 0; m_rd = 0; m_odata = 0; m_func = 0;
    m_cnt = 0; m_oaddr = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
  endtask

  task automatic model_step();
    bit go, clr, ok;
    int a;
    go  = bus_we && (bus_addr == A_GO) && bus_wdata[0];
    clr = 0;
    if (m_busy) begin
      if (m_cnt == 0) begin
        m_busy = 0; clr = 1;
        if (m_prog) begin
          if ((m_mem[m_oaddr] & ~m_odata) != 8'h00) m_fail = 1;
          else begin m_mem[m_oaddr] = m_mem[m_oaddr] | m_odata; m_fail = 0; end
        end else begin
          m_rd = m_mem[m_oaddr]; m_fail = 0;
        end
      end else m_cnt--;
    end else if (go) begin
      a  = m_ahi * 256 + m_alo;
      ok = !m_pwrdn && m_lock && a < DEPTH && (m_func == 1 || (m_func == 2 && m_mode));
      if (ok) begin
        m_busy = 1; m_fail = 0; m_prog = (m_func == 2);
        m_cnt = m_prog ? 15 : 3; m_oaddr = a; m_odata = m_pdata;
      end else begin
        m_fail = 1; clr = 1;
      end
    end
    if (bus_we) begin
      case (bus_addr)
        A_LOCK:  m_lock  = bus_wdata[5];
        A_PWRDN: m_pwrdn = bus_wdata[0];
        A_AHI:   m_ahi   = bus_wdata[4:0];
        A_ALO:   m_alo   = bus_wdata[7:0];
        A_PDATA: m_pdata = bus_wdata[7:0];
        A_PMODE: m_mode  = bus_wdata[0];
        A_FUNC:  m_func  = bus_wdata[1:0];
        default: ;
      endcase
    end
    if (clr) m_func = 2'b00;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  // compare against the reference every cycle
  always @(negedge clk) begin
    #2;
    if (cmp_en && !finished && !bus_we)
      chk(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
  end

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_we = 0;
    #1;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic set_addr(input int a);
    wr(A_AHI, 32'(a >> 8));
    wr(A_ALO, 32'(a & 255));
  endtask

  task automatic do_op(input logic [1:0] f);
    wr(A_FUNC, {30'b0, f});
    wr(A_GO, 32'h1);
  endtask

  task automatic poll(output int n);
    n = 0;
    bus_addr = A_STAT; bus_we = 0;
    #1;
    while (bus_rdata[0] && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_en = 1;

    rd(A_PWRDN, 32'h1, "R1 power-down set after reset");
    rd(A_LOCK,  32'h0, "R1 lock free after reset");
    rd(A_STAT,  32'h0, "R1 idle after reset");
    rd(A_PF,    32'h0, "R1 pass/fail clear after reset");
    rd(A_RDATA, 32'h0, "R1 read data zero after reset");

    wr(A_LOCK, 32'h20);        rd(A_LOCK, 32'h20, "R2 lock granted");
    wr(A_LOCK, 32'h0);         rd(A_LOCK, 32'h0,  "R2 lock released");
    wr(A_LOCK, 32'hFFFF_FFDF); rd(A_LOCK, 32'h0,  "R2 other bits ignored");
    wr(A_LOCK, 32'h20);

    set_addr(5); do_op(2'b01);
    rd(A_PF,   32'h1, "R7 go while powered down fails");
    rd(A_STAT, 32'h0, "R7 refused go never busy");
    rd(A_FUNC, 32'h0, "R8 command cleared on refusal");

    wr(A_PWRDN, 32'h0); rd(A_PWRDN, 32'h0, "R10 power-down cleared");
    wr(A_ALO, 32'h1AB); rd(A_ALO, 32'hAB, "R3 low address masked");
    wr(A_AHI, 32'hFF);  rd(A_AHI, 32'h1F, "R3 high address masked");

    set_addr(5); do_op(2'b01); poll(n);
    chk("R4 read busy length", n, 4);
    rd(A_PF, 32'h0, "R4 read passes");
    rd(A_RDATA, 32'h0, "R4 fresh byte reads zero");
    rd(A_FUNC, 32'h0, "R8 command cleared after read");

    wr(A_PMODE, 32'h1); wr(A_PDATA, 32'h5A); do_op(2'b10); poll(n);
    chk("R5 program busy length", n, 16);
    rd(A_PF, 32'h0, "R5 program passes");
    do_op(2'b01); poll(n); rd(A_RDATA, 32'h5A, "R5 programmed byte");
    wr(A_PDATA, 32'hFA); do_op(2'b10); poll(n);
    rd(A_PF, 32'h0, "R5 superset program passes");
    do_op(2'b01); poll(n); rd(A_RDATA, 32'hFA, "R5 bits ORed in");

    wr(A_PDATA, 32'h0F); do_op(2'b10); poll(n);
    rd(A_PF, 32'h1, "R6 clearing a set bit fails");
    do_op(2'b01); poll(n); rd(A_RDATA, 32'hFA, "R6 byte unchanged");

    wr(A_PMODE, 32'h0); wr(A_PDATA, 32'hFF); do_op(2'b10);
    rd(A_PF, 32'h1, "R7 program without mode fails");
    rd(A_STAT, 32'h0, "R7 mode refusal idle");
    do_op(2'b01); poll(n); rd(A_RDATA, 32'hFA, "R7 array unchanged after mode refusal");
    do_op(2'b11); rd(A_PF, 32'h1, "R7 both command bits fail");
    do_op(2'b01); poll(n); do_op(2'b00); rd(A_PF, 32'h1, "R7 empty command fails");
    wr(A_LOCK, 32'h0); do_op(2'b01);
    rd(A_PF, 32'h1, "R7 go without lock fails");
    rd(A_RDATA, 32'hFA, "R7 read data kept after refusal");
    wr(A_LOCK, 32'h20);
    do_op(2'b01); poll(n); set_addr(DEPTH); do_op(2'b01);
    rd(A_PF, 32'h1, "R7 address at DEPTH fails");
    set_addr(13'h1000); do_op(2'b01);
    rd(A_PF, 32'h1, "R7 top address fails");

    wr(A_PMODE, 32'h1);
    set_addr(DEPTH - 1); wr(A_PDATA, 32'h81); do_op(2'b10); poll(n);
    do_op(2'b01); poll(n); rd(A_RDATA, 32'h81, "R3 last in-range byte");
    set_addr(13'h100); wr(A_PDATA, 32'h33); do_op(2'b10); poll(n);
    set_addr(0); do_op(2'b01); poll(n); rd(A_RDATA, 32'h00, "R3 high bits separate bytes");
    set_addr(13'h100); do_op(2'b01); poll(n); rd(A_RDATA, 32'h33, "R3 high-address byte");

    set_addr(5); do_op(2'b01); wr(A_GO, 32'h1); poll(n);
    chk("R9 go while busy does not extend", n, 3);
    rd(A_PF, 32'h0, "R9 ignored go leaves pass");
    rd(A_RDATA, 32'hFA, "R9 original operation result");

    wr(A_PWRDN, 32'h1); rd(A_PWRDN, 32'h1, "R10 power-down set again");
    do_op(2'b01); rd(A_PF, 32'h1, "R10 go after shutdown fails");

    finished = 1;
    summary();
    $finish;
  end
endmodule